// File: doc/BRIEF.md
# Inhibit-Frozen Angle Byte Reader

This block sits between an angle word that updates every clock and a byte-wide shared bus. A hold register follows the live angle on every clock while the active-low inhibit is high. Once inhibit is sampled low, it keeps its value, so a reader sees a stable angle while the tracking logic upstream keeps running. Releasing inhibit makes the register follow the live angle again at the next clock edge.

Two read ports, A and B, each have an active-low upper-byte enable and an active-low lower-byte enable. The upper byte is the top 8 bits of the held angle. The lower byte holds the remaining low bits, left-justified and padded with zeros. With no enable asserted, the bus output-enable is low and the data lines are driven to zero. A tri-state pad is built from these two outputs. If more than one enable is asserted, a fixed priority picks one read and a contention flag is raised. The bus outputs are registered, so a read shows up one clock after the enable is sampled.

Top module: `angle_byte_out`

## Requirements
- R1: While reset is asserted, `bus_o`, `bus_oe_o` and `contention_o` are all zero, and the held angle is zero.
- R2: At every clock edge where `inh_ni` is 1, the held angle takes the value of `angle_i`.
- R3: At every clock edge where `inh_ni` is 0, the held angle keeps its value, and changes on `angle_i` have no effect on the bytes that are read out.
- R4: After `inh_ni` returns to 1, the held angle follows `angle_i` again from the next clock edge.
- R5: If all four enables are 1 at a clock edge, then after that edge `bus_oe_o` is 0 and `bus_o` is 0.
- R6: An upper-byte read drives `bus_o` = held angle bits [ANGLE_W-1:ANGLE_W-8], with `bus_oe_o` = 1.
- R7: A lower-byte read drives `bus_o` = held angle bits [ANGLE_W-9:0] in bus bits [7:16-ANGLE_W], with zeros in the bus bits below them.
- R8: Port A and port B return identical bytes for the same held angle.
- R9: The priority order is `em_a_ni`, then `el_a_ni`, then `em_b_ni`, then `el_b_ni`. The asserted enable that comes first in this order selects the byte.
- R10: `contention_o` is 1 after an edge where two or more enables are 0, and 0 otherwise.
- R11: The byte and the enable appear on the first clock edge at which an enable is sampled. The byte is built from the held angle as it stood just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| angle_i | input | ANGLE_W | Live angle word, updated continuously |
| inh_ni | input | 1 | Inhibit, active low; freezes the held angle |
| em_a_ni | input | 1 | Port A upper-byte enable, active low |
| el_a_ni | input | 1 | Port A lower-byte enable, active low |
| em_b_ni | input | 1 | Port B upper-byte enable, active low |
| el_b_ni | input | 1 | Port B lower-byte enable, active low |
| bus_o | output | 8 | Bus data, zero when not driven |
| bus_oe_o | output | 1 | Bus output-enable for the tri-state pad |
| contention_o | output | 1 | More than one enable was asserted |

## Verification
The bound checker watches, on every cycle, the following behaviours:
- tracking and freezing of the held angle;
- the released bus when no enable is asserted;
- the contention flag;
- the bytes chosen by the two highest-priority enables, each against the held value one cycle earlier.

Some behaviours can only be shown by the bench's scenarios:
- that a frozen angle survives while `angle_i` changes under it;
- that a read made after release returns the new angle;
- that ports A and B agree across a sweep of angle values;
- that all sixteen enable patterns resolve in the stated priority order.

// File: rtl/angle_out_pkg.sv
package angle_out_pkg;
  localparam int NUM_EN = 4;
  // enable index order is also the priority order
  localparam int EN_MA = 0;
  localparam int EN_LA = 1;
  localparam int EN_MB = 2;
  localparam int EN_LB = 3;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_MSB  = 2'd1,
    SEL_LSB  = 2'd2
  } sel_e;
endpackage

// File: rtl/angle_hold_reg.sv
module angle_hold_reg #(
  parameter int ANGLE_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               inh_ni,
  input  logic [ANGLE_W-1:0] angle_i,
  output logic [ANGLE_W-1:0] hold_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hold_o <= '0;
    else if (inh_ni) hold_o <= angle_i;
  end
endmodule

// File: rtl/en_priority.sv
module en_priority
  import angle_out_pkg::*;
(
  input  logic [NUM_EN-1:0] en_n_i,
  output sel_e              sel_o,
  output logic              multi_o
);
  logic [NUM_EN-1:0] act;
  logic [2:0]        cnt;

  assign act = ~en_n_i;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NUM_EN; i++) cnt = cnt + 3'(act[i]);
  end
  assign multi_o = (cnt > 3'd1);

  always_comb begin
    sel_o = SEL_NONE;
    for (int i = NUM_EN - 1; i >= 0; i--) begin
      if (act[i]) sel_o = (i % 2 == 0) ? SEL_MSB : SEL_LSB;
    end
  end
endmodule

// File: rtl/byte_format.sv
module byte_format
  import angle_out_pkg::*;
#(
  parameter int ANGLE_W = 12
) (
  input  logic [ANGLE_W-1:0] hold_i,
  input  sel_e               sel_i,
  output logic [7:0]         byte_o
);
  localparam int LOW_W = ANGLE_W - 8;
  localparam int PAD_W = 8 - LOW_W;

  logic [7:0] hi_byte;
  logic [7:0] lo_byte;

  assign hi_byte = hold_i[ANGLE_W-1 -: 8];

  generate
    if (PAD_W == 0) begin : g_full
      assign lo_byte = hold_i[7:0];
    end else begin : g_pad
      assign lo_byte = {hold_i[LOW_W-1:0], {PAD_W{1'b0}}};
    end
  endgenerate

  always_comb begin
    unique case (sel_i)
      SEL_MSB: byte_o = hi_byte;
      SEL_LSB: byte_o = lo_byte;
      default: byte_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/angle_byte_out.sv
module angle_byte_out
  import angle_out_pkg::*;
#(
  parameter int ANGLE_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ANGLE_W-1:0] angle_i,
  input  logic               inh_ni,
  input  logic               em_a_ni,
  input  logic               el_a_ni,
  input  logic               em_b_ni,
  input  logic               el_b_ni,
  output logic [7:0]         bus_o,
  output logic               bus_oe_o,
  output logic               contention_o
);
  logic [ANGLE_W-1:0] hold_q;
  logic [NUM_EN-1:0]  en_n;
  sel_e               sel;
  logic               multi;
  logic [7:0]         byte_d;

  assign en_n[EN_MA] = em_a_ni;
  assign en_n[EN_LA] = el_a_ni;
  assign en_n[EN_MB] = em_b_ni;
  assign en_n[EN_LB] = el_b_ni;

  angle_hold_reg #(.ANGLE_W(ANGLE_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inh_ni (inh_ni),
    .angle_i(angle_i),
    .hold_o (hold_q)
  );

  en_priority u_prio (
    .en_n_i (en_n),
    .sel_o  (sel),
    .multi_o(multi)
  );

  byte_format #(.ANGLE_W(ANGLE_W)) u_fmt (
    .hold_i(hold_q),
    .sel_i (sel),
    .byte_o(byte_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_o        <= '0;
      bus_oe_o     <= 1'b0;
      contention_o <= 1'b0;
    end else begin
      bus_o        <= byte_d;
      bus_oe_o     <= (sel != SEL_NONE);
      contention_o <= multi;
    end
  end
endmodule

// File: rtl/angle_byte_out_chk.sv
module angle_byte_out_chk #(
  parameter int ANGLE_W = 12
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ANGLE_W-1:0] angle_i,
  input logic               inh_ni,
  input logic               em_a_ni,
  input logic               el_a_ni,
  input logic               em_b_ni,
  input logic               el_b_ni,
  input logic [7:0]         bus_o,
  input logic               bus_oe_o,
  input logic               contention_o,
  input logic [ANGLE_W-1:0] hold_q
);
  logic [3:0]  act;
  logic [15:0] wide;
  logic [7:0]  lo_ref;

  assign act    = ~{el_b_ni, em_b_ni, el_a_ni, em_a_ni};
  assign wide   = 16'(hold_q) << (16 - ANGLE_W);
  assign lo_ref = wide[7:0];

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_zero_chk: assert (bus_o == 8'h00 && !bus_oe_o && !contention_o && hold_q == '0);
    end
  end

  // R2
  track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inh_ni |=> hold_q == $past(angle_i));

  // R3
  freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inh_ni |=> $stable(hold_q));

  // R5
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act == 4'b0000) |=> (!bus_oe_o && bus_o == 8'h00));

  // R6
  msb_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !em_a_ni |=> (bus_oe_o && bus_o == $past(hold_q[ANGLE_W-1 -: 8])));

  // R7
  lsb_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (em_a_ni && !el_a_ni) |=> (bus_oe_o && bus_o == $past(lo_ref)));

  // R10
  contention_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(act) > 1) |=> contention_o);

  // R10
  contention_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(act) |=> !contention_o);
endmodule

bind angle_byte_out angle_byte_out_chk #(.ANGLE_W(ANGLE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .angle_i     (angle_i),
  .inh_ni      (inh_ni),
  .em_a_ni     (em_a_ni),
  .el_a_ni     (el_a_ni),
  .em_b_ni     (em_b_ni),
  .el_b_ni     (el_b_ni),
  .bus_o       (bus_o),
  .bus_oe_o    (bus_oe_o),
  .contention_o(contention_o),
  .hold_q      (hold_q)
);

// File: tb/angle_byte_out_test.sv
module angle_byte_out_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] angle = '0;
  logic         inh_n = 1'b1;
  logic         em_a = 1'b1, el_a = 1'b1, em_b = 1'b1, el_b = 1'b1;
  logic [7:0]   bus;
  logic         oe, cont;
  int           checks = 0, errors = 0;
  bit           done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  angle_byte_out #(.ANGLE_W(W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .angle_i(angle), .inh_ni(inh_n),
    .em_a_ni(em_a), .el_a_ni(el_a), .em_b_ni(em_b), .el_b_ni(el_b),
    .bus_o(bus), .bus_oe_o(oe), .contention_o(cont)
  );

  function automatic logic [7:0] hi_of(int v);
    return 8'((v >> 4) & 255);
  endfunction

  function automatic logic [7:0] lo_of(int v);
    return 8'((v & 15) * 16);
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_en(logic [3:0] pat); // bit set = asserted; 0=em_a 1=el_a 2=em_b 3=el_b
    em_a = ~pat[0]; el_a = ~pat[1]; em_b = ~pat[2]; el_b = ~pat[3];
  endtask

  task automatic read(logic [3:0] pat, string req, int exp);
    set_en(pat);
    step();
    chk(req, int'(oe), 1);
    chk(req, int'(bus), exp);
    set_en(4'b0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    // R1 reset state
    chk("R1 bus", int'(bus), 0);
    chk("R1 oe", int'(oe), 0);
    chk("R1 contention", int'(cont), 0);
    rst_ni = 1'b1;
    step();
    chk("R1 oe after release", int'(oe), 0);

    // R5 idle: no enable
    angle = 12'hABC;
    step();
    step();
    chk("R5 oe idle", int'(oe), 0);
    chk("R5 bus idle", int'(bus), 0);

    // sweep angles: freeze, disturb input, read all four bytes, release
    for (int v = 0; v < 4096; v += 37) begin
      int nv;
      nv = (~v) & 12'hFFF;
      angle = W'(v);
      inh_n = 1'b1;
      step();
      inh_n = 1'b0;
      angle = W'(nv);          // R3 input change while frozen
      step();
      step();
      read(4'b0001, "R6 R3 A msb", int'(hi_of(v)));
      read(4'b0010, "R7 R3 A lsb", int'(lo_of(v)));
      read(4'b0100, "R8 B msb", int'(hi_of(v)));
      read(4'b1000, "R8 B lsb", int'(lo_of(v)));
      step();
      chk("R5 bus released", int'(oe), 0);
      inh_n = 1'b1;            // R4 release: next edge captures nv
      step();
      read(4'b0001, "R4 msb after release", int'(hi_of(nv)));
      read(4'b0010, "R4 lsb after release", int'(lo_of(nv)));
    end

    // boundary angles
    for (int k = 0; k < 2; k++) begin
      int v;
      v = (k == 0) ? 0 : 12'hFFF;
      angle = W'(v);
      inh_n = 1'b1;
      step();
      inh_n = 1'b0;
      step();
      read(4'b0001, "R6 boundary", int'(hi_of(v)));
      read(4'b1000, "R7 boundary", int'(lo_of(v)));
    end

    // R2 R11 continuous tracking read with inhibit high
    inh_n = 1'b1;
    begin
      int prev;
      prev = 12'hFFF;
      angle = W'(prev);
      step();
      set_en(4'b0001);
      for (int i = 0; i < 40; i++) begin
        int nxt;
        nxt = (i * 293 + 17) & 12'hFFF;
        angle = W'(nxt);
        step();
        // bus built from hold before this edge = angle driven before previous edge
        chk("R2 R11 tracking msb", int'(bus), int'(hi_of(prev)));
        prev = nxt;
      end
      set_en(4'b0000);
    end

    // R11 single-cycle latency: enable pulse for one cycle
    angle = 12'h5A3;
    inh_n = 1'b1;
    step();
    inh_n = 1'b0;
    step();
    set_en(4'b0010);
    step();
    set_en(4'b0000);
    chk("R11 oe first edge", int'(oe), 1);
    chk("R11 byte first edge", int'(bus), int'(lo_of(12'h5A3)));
    step();
    chk("R11 oe drops next edge", int'(oe), 0);

    // R9 R10 exhaustive enable patterns on frozen angle
    for (int p = 0; p < 16; p++) begin
      int first, n, exp_b;
      first = -1;
      n = 0;
      for (int b = 3; b >= 0; b--) if (p[b]) begin first = b; n++; end
      set_en(4'(p));
      step();
      exp_b = (first < 0) ? 0 : ((first % 2 == 0) ? int'(hi_of(12'h5A3)) : int'(lo_of(12'h5A3)));
      chk("R9 priority byte", int'(bus), exp_b);
      chk("R9 priority oe", int'(oe), (first < 0) ? 0 : 1);
      chk("R10 contention", int'(cont), (n > 1) ? 1 : 0);
    end
    set_en(4'b0000);
    step();
    chk("R10 contention clear", int'(cont), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule